// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight condition and mode flags of a small processor core, plus one hidden emulation bit that sits outside the visible byte. The core's control logic steers it through a single command port (one command per cycle) and an independent flag-update port that the ALU drives whenever an instruction produces new condition codes. Commands cover a full byte load (used when the status byte is pulled back from the stack), setting or clearing every bit named in an immediate mask, setting or clearing one bit picked by index, and swapping the carry flag with the emulation bit in a single cycle.

A separate request input marks the start of a software interrupt: it forces the interrupt-disable flag on and the decimal flag off. The two operand-width flags go straight to the datapath as narrow-accumulator and narrow-index selects. While the emulation bit is set, both width flags are held at 1, so the core cannot leave its 8-bit widths without first leaving emulation.

Flag layout (bit position: meaning): 7 negative, 6 overflow, 5 accumulator width (1 = 8-bit), 4 index width (1 = 8-bit), 3 decimal, 2 interrupt disable, 1 zero, 0 carry.

Top module: `psr_status_unit`

## Requirements
- R1: While `rst_n` is low and after it goes high, the status byte reads 0x34 (interrupt disable set, decimal clear, both width flags set, all else clear) and `emu_mode` reads 1.
- R2: `cmd_op` = 1 (load) writes `cmd_data` into the status byte at the next clock edge, except that bits 5 and 4 stay 1 while the emulation bit is 1.
- R3: `cmd_op` = 2 (masked set) sets every status bit whose position is 1 in `cmd_data`, leaving the others as the flag-update port leaves them.
- R4: `cmd_op` = 3 (masked clear) clears every status bit whose position is 1 in `cmd_data`, except bits 5 and 4 while the emulation bit is 1.
- R5: `cmd_op` = 4 sets and `cmd_op` = 5 clears the single status bit whose index is `cmd_data[2:0]`; the upper bits of `cmd_data` are ignored.
- R6: `cmd_op` = 6 (exchange) moves the old carry (bit 0) into the emulation bit and the old emulation bit into carry at the same edge; entering emulation forces bits 5 and 4 to 1.
- R7: When `alu_we` is 1, each status bit whose position is 1 in `alu_sel` takes the matching bit of `alu_flags`; bits not selected hold.
- R8: A command outranks the flag-update port: a load replaces all eight bits regardless of `alu_we`, and a masked or single-bit command wins on the bits it names while the flag-update port still writes its other selected bits.
- R9: `int_enter` = 1 sets bit 2 and clears bit 3 at the next edge, overriding any command or flag update on those two bits in the same cycle.
- R10: While `emu_mode` is 1, bits 5 and 4 read 1; `acc_narrow` always equals bit 5 and `idx_narrow` always equals bit 4.
- R11: With `cmd_op` = 0 or 7, `alu_we` = 0 and `int_enter` = 0, the status byte and the emulation bit hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Command code: 0 none, 1 load, 2 masked set, 3 masked clear, 4 bit set, 5 bit clear, 6 exchange, 7 none |
| cmd_data | input | 8 | Load value, mask, or bit index in bits 2:0 |
| alu_we | input | 1 | Flag-update strobe from the ALU |
| alu_sel | input | 8 | Which status bits the ALU update writes |
| alu_flags | input | 8 | New flag values from the ALU |
| int_enter | input | 1 | Software-interrupt entry request |
| status | output | 8 | Current status byte |
| emu_mode | output | 1 | Current emulation bit |
| acc_narrow | output | 1 | Accumulator is 8-bit |
| idx_narrow | output | 1 | Index registers are 8-bit |

## Verification
The collisions that matter are a command landing in the same cycle as an ALU flag update, and an interrupt entry landing on top of a load or masked write that touches the interrupt-disable or decimal bit. The stimulus drives the flag-update port on roughly half the cycles while every command code is issued, and raises the interrupt request on a fraction of them, so both collisions occur many times alongside directed cases such as a load of 0x08 together with interrupt entry. Each result is judged against a bench model that applies the ALU update first, the command over it, interrupt entry over both, and the emulation width hold last.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int FLAG_W = 8;

    localparam int POS_C = 0;
    localparam int POS_Z = 1;
    localparam int POS_I = 2;
    localparam int POS_D = 3;
    localparam int POS_X = 4;
    localparam int POS_M = 5;
    localparam int POS_V = 6;
    localparam int POS_N = 7;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_LOAD = 3'd1,
        OP_MSET = 3'd2,
        OP_MCLR = 3'd3,
        OP_BSET = 3'd4,
        OP_BCLR = 3'd5,
        OP_SWAP = 3'd6,
        OP_RSVD = 3'd7
    } psr_op_e;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic              emu;
    } psr_state_t;

endpackage

// File: rtl/psr_cmd_decode.sv
module psr_cmd_decode
    import psr_pkg::*;
#(
    parameter int W = FLAG_W
) (
    input  psr_op_e        op,
    input  logic [W-1:0]   data,
    input  logic           emu_cur,
    output logic [W-1:0]   ovr_mask,
    output logic [W-1:0]   ovr_val,
    output logic           swap_hit
);
    localparam int IDX_W = $clog2(W);

    logic [W-1:0] bit_onehot;

    for (genvar i = 0; i < W; i++) begin : g_onehot
        assign bit_onehot[i] = (data[IDX_W-1:0] == IDX_W'(i));
    end

    always_comb begin
        ovr_mask = '0;
        ovr_val  = '0;
        swap_hit = 1'b0;
        unique case (op)
            OP_LOAD: begin
                ovr_mask = '1;
                ovr_val  = data;
            end
            OP_MSET: begin
                ovr_mask = data;
                ovr_val  = '1;
            end
            OP_MCLR: begin
                ovr_mask = data;
                ovr_val  = '0;
            end
            OP_BSET: begin
                ovr_mask = bit_onehot;
                ovr_val  = '1;
            end
            OP_BCLR: begin
                ovr_mask = bit_onehot;
                ovr_val  = '0;
            end
            OP_SWAP: begin
                ovr_mask[POS_C] = 1'b1;
                ovr_val[POS_C]  = emu_cur;
                swap_hit        = 1'b1;
            end
            default: begin
                ovr_mask = '0;
                ovr_val  = '0;
            end
        endcase
    end

endmodule

// File: rtl/psr_next.sv
module psr_next
    import psr_pkg::*;
#(
    parameter int W = FLAG_W
) (
    input  psr_state_t     cur,
    input  logic           alu_we,
    input  logic [W-1:0]   alu_sel,
    input  logic [W-1:0]   alu_val,
    input  logic [W-1:0]   ovr_mask,
    input  logic [W-1:0]   ovr_val,
    input  logic           swap_hit,
    input  logic           int_enter,
    output psr_state_t     nxt
);
    logic         emu_nxt;
    logic [W-1:0] lane;

    assign emu_nxt = swap_hit ? cur.flags[POS_C] : cur.emu;

    for (genvar i = 0; i < W; i++) begin : g_lane
        logic after_alu;
        logic after_cmd;

        assign after_alu = (alu_we && alu_sel[i]) ? alu_val[i] : cur.flags[i];
        assign after_cmd = ovr_mask[i] ? ovr_val[i] : after_alu;

        if (i == POS_I) begin : g_irq_dis
            assign lane[i] = after_cmd | int_enter;
        end else if (i == POS_D) begin : g_dec
            assign lane[i] = after_cmd & ~int_enter;
        end else if (i == POS_M || i == POS_X) begin : g_width
            assign lane[i] = after_cmd | emu_nxt;
        end else begin : g_plain
            assign lane[i] = after_cmd;
        end
    end

    always_comb begin
        nxt.flags = lane;
        nxt.emu   = emu_nxt;
    end

endmodule

// File: rtl/psr_status_unit.sv
module psr_status_unit
    import psr_pkg::*;
#(
    parameter int W = FLAG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   cmd_op,
    input  logic [W-1:0] cmd_data,
    input  logic         alu_we,
    input  logic [W-1:0] alu_sel,
    input  logic [W-1:0] alu_flags,
    input  logic         int_enter,
    output logic [W-1:0] status,
    output logic         emu_mode,
    output logic         acc_narrow,
    output logic         idx_narrow
);
    localparam logic [W-1:0] RESET_FLAGS =
        W'((1 << POS_I) | (1 << POS_M) | (1 << POS_X));
    localparam logic [W-1:0] WIDTH_BITS =
        W'((1 << POS_M) | (1 << POS_X));

    psr_op_e      op_w;
    logic [W-1:0] ovr_mask_w;
    logic [W-1:0] ovr_val_w;
    logic         swap_w;
    psr_state_t   nxt_w;
    psr_state_t   state_d;
    psr_state_t   state_q;

    assign op_w = psr_op_e'(cmd_op);

    psr_cmd_decode #(.W(W)) u_decode (
        .op       (op_w),
        .data     (cmd_data),
        .emu_cur  (state_q.emu),
        .ovr_mask (ovr_mask_w),
        .ovr_val  (ovr_val_w),
        .swap_hit (swap_w)
    );

    psr_next #(.W(W)) u_next (
        .cur       (state_q),
        .alu_we    (alu_we),
        .alu_sel   (alu_sel),
        .alu_val   (alu_flags),
        .ovr_mask  (ovr_mask_w),
        .ovr_val   (ovr_val_w),
        .swap_hit  (swap_w),
        .int_enter (int_enter),
        .nxt       (nxt_w)
    );

    always_comb begin
        state_d = nxt_w;
        if (!rst_n) begin
            state_d.flags = RESET_FLAGS;
            state_d.emu   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign status     = state_q.flags;
    assign emu_mode   = state_q.emu;
    assign acc_narrow = state_q.flags[POS_M];
    assign idx_narrow = state_q.flags[POS_X];

    AST_EMU_WIDTH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        emu_mode |-> (acc_narrow && idx_narrow)); // R10

    AST_SWAP_EXCHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_w == OP_SWAP) |=> (emu_mode == $past(status[POS_C]))
                              && (status[POS_C] == $past(emu_mode))); // R6

    AST_INT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        int_enter |=> (status[POS_I] && !status[POS_D])); // R9

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_w == OP_LOAD && !int_enter) |=>
            status == ($past(cmd_data) | (emu_mode ? WIDTH_BITS : '0))); // R2

    AST_MASK_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_w == OP_MSET && !int_enter) |=>
            ((status & $past(cmd_data)) == $past(cmd_data))); // R3

    AST_MASK_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_w == OP_MCLR && !int_enter) |=>
            ((status & $past(cmd_data) & ~(emu_mode ? WIDTH_BITS : '0)) == '0)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_w == OP_NONE || op_w == OP_RSVD) && !alu_we && !int_enter) |=>
            ($stable(status) && $stable(emu_mode))); // R11

endmodule

// File: tb/psr_status_unit_bench.sv
`timescale 1ns/1ps
module psr_status_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] cmd_op;
    logic [7:0] cmd_data;
    logic       alu_we;
    logic [7:0] alu_sel;
    logic [7:0] alu_flags;
    logic       int_enter;
    logic [7:0] status;
    logic       emu_mode;
    logic       acc_narrow;
    logic       idx_narrow;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [7:0] exp_f;
    logic       exp_e;

    always #2.5 clk = ~clk;

    psr_status_unit u_psr_status_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_op     (cmd_op),
        .cmd_data   (cmd_data),
        .alu_we     (alu_we),
        .alu_sel    (alu_sel),
        .alu_flags  (alu_flags),
        .int_enter  (int_enter),
        .status     (status),
        .emu_mode   (emu_mode),
        .acc_narrow (acc_narrow),
        .idx_narrow (idx_narrow)
    );

    // Reference: ALU first, command over it, interrupt entry, then width hold.
    function automatic logic [8:0] model_step(input logic [7:0] f, input logic e,
            input logic [2:0] op, input logic [7:0] d, input logic aw,
            input logic [7:0] as, input logic [7:0] av, input logic ie);
        logic [7:0] r;
        logic       ne;
        r  = f;
        ne = e;
        for (int b = 0; b < 8; b++)
            if (aw && as[b]) r[b] = av[b];
        case (op)
            3'd1: r = d;
            3'd2: r = r | d;
            3'd3: r = r & ~d;
            3'd4: r[d[2:0]] = 1'b1;
            3'd5: r[d[2:0]] = 1'b0;
            3'd6: begin r[0] = e; ne = f[0]; end
            default: ;
        endcase
        if (ie) begin r[2] = 1'b1; r[3] = 1'b0; end
        if (ne) r[5:4] = 2'b11;
        return {ne, r};
    endfunction

    function automatic string op_tag(input logic [2:0] op, input logic aw, input logic ie);
        if (ie) return "R9";
        case (op)
            3'd1: return aw ? "R8" : "R2";
            3'd2: return aw ? "R8" : "R3";
            3'd3: return aw ? "R8" : "R4";
            3'd4, 3'd5: return "R5";
            3'd6: return "R6";
            default: return aw ? "R7" : "R11";
        endcase
    endfunction

    task automatic check(input string tag);
        checks++;
        if (status !== exp_f || emu_mode !== exp_e ||
            acc_narrow !== exp_f[5] || idx_narrow !== exp_f[4]) begin
            failures++;
            $display("FAIL %s: status=%02h emu=%0b acc=%0b idx=%0b expected status=%02h emu=%0b",
                     tag, status, emu_mode, acc_narrow, idx_narrow, exp_f, exp_e);
        end
    endtask

    task automatic step(input string tag, input logic [2:0] op, input logic [7:0] d,
                        input logic aw, input logic [7:0] as, input logic [7:0] av,
                        input logic ie);
        logic [8:0] nx;
        cmd_op    = op;
        cmd_data  = d;
        alu_we    = aw;
        alu_sel   = as;
        alu_flags = av;
        int_enter = ie;
        nx = model_step(exp_f, exp_e, op, d, aw, as, av, ie);
        @(posedge clk);
        @(negedge clk);
        {exp_e, exp_f} = nx;
        check(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; cmd_op = 3'd0; cmd_data = 8'h00;
        alu_we = 1'b0; alu_sel = 8'h00; alu_flags = 8'h00; int_enter = 1'b0;
        exp_f = 8'h34; exp_e = 1'b1;
        // Reset with busy inputs must still land on the reset value.
        repeat (2) @(negedge clk);
        cmd_op = 3'd1; cmd_data = 8'hFF; alu_we = 1'b1; alu_sel = 8'hFF;
        @(negedge clk);
        check("R1");
        cmd_op = 3'd0; cmd_data = 8'h00; alu_we = 1'b0; alu_sel = 8'h00;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1");

        step("R10", 3'd1, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0); // widths held: 0x30
        step("R4",  3'd3, 8'hFF, 1'b0, 8'h00, 8'h00, 1'b0); // clear all, widths stay
        step("R6",  3'd6, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0); // leave emulation, C=1
        step("R2",  3'd1, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0); // widths now clearable
        step("R2",  3'd1, 8'hC3, 1'b0, 8'h00, 8'h00, 1'b0);
        step("R3",  3'd2, 8'h30, 1'b0, 8'h00, 8'h00, 1'b0);
        step("R4",  3'd3, 8'hF0, 1'b0, 8'h00, 8'h00, 1'b0);
        step("R5",  3'd4, 8'hF7, 1'b0, 8'h00, 8'h00, 1'b0); // upper data ignored, bit 7
        step("R5",  3'd5, 8'h08, 1'b0, 8'h00, 8'h00, 1'b0); // index 0 clears carry
        step("R7",  3'd0, 8'h00, 1'b1, 8'hC3, 8'h81, 1'b0);
        step("R11", 3'd7, 8'hFF, 1'b0, 8'hFF, 8'hFF, 1'b0);
        step("R8",  3'd1, 8'h5A, 1'b1, 8'hFF, 8'hA5, 1'b0); // load beats ALU
        step("R8",  3'd2, 8'h01, 1'b1, 8'h81, 8'h00, 1'b0); // mask wins bit 0, ALU bit 7
        step("R9",  3'd1, 8'h08, 1'b1, 8'h0C, 8'h08, 1'b1);
        step("R6",  3'd6, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0); // carry into emulation
        step("R10", 3'd3, 8'h30, 1'b1, 8'h30, 8'h00, 1'b0);

        for (int n = 0; n < 4000; n++) begin
            logic [2:0] op;
            logic [7:0] d;
            logic       aw;
            logic       ie;
            op = 3'($urandom_range(0, 7));
            d  = 8'($urandom);
            aw = ($urandom_range(0, 1) == 1);
            ie = ($urandom_range(0, 7) == 0);
            step(op_tag(op, aw, ie), op, d, aw, 8'($urandom), 8'($urandom), ie);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule